// File: doc/BRIEF.md
# Calendar Time Counter with Binary/BCD and 12/24-Hour Formats

This block keeps wall-clock time and a calendar in seven parallel registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A single-cycle pulse from an external one-second prescaler moves the whole chain forward by one second. Each carry ripples upward through minutes, hours, days, months and years. Month lengths follow the calendar, and February has 29 days in every year whose value divides by four.

Three plain control inputs choose how the registers appear at the ports. One selects plain binary or packed BCD. One selects a 24-hour clock or a 12-hour clock with a PM flag. One enables the automatic spring-forward and fall-back hour shifts. Time is held internally as binary, so switching format changes only how the same instant is shown.

A host loads fields through a small write channel with a valid/ready handshake. The channel is ready only while the freeze input is high. While frozen, second pulses are discarded, so the host can load a consistent set of fields without racing an advance. A field transfers on each clock edge where both valid and ready are high. A host that finds ready low may hold valid and its data steady until ready rises. A strobe marks every completed advance.

Top module: `calendar_counter`

## Requirements
- R1: After reset the fields read seconds 0, minutes 0, hours 0, day of week 1, date 1, month 1, year 0, and the update strobe is low.
- R2: A clock edge with the tick high and freeze low adds one second. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the date and the day of week.
- R3: Day of week counts 1 to 7 and returns to 1 on the next day carry.
- R4: Date returns to 1 after the last day of the month and the month advances. Months 4, 6, 9 and 11 have 30 days; the other months except February have 31. Month 12 wraps to 1 and increments the year, and year 99 wraps to 0.
- R5: February has 29 days when the year value is a multiple of 4 (0 included) and 28 days otherwise.
- R6: With binary mode high, fields read and write as plain binary. With it low they are packed BCD, tens in bits 7:4 and units in bits 3:0. Changing the mode changes only the presentation of the stored time.
- R7: With 24-hour mode low, the hours field holds 1 to 12 in bits 6:0 and bit 7 is the PM flag. Time runs 11 AM, 12 PM, 1 PM, and 11 PM, 12 AM with a day carry. In BCD, 12 PM reads 0x92 and 12 AM reads 0x12.
- R8: With daylight saving enabled, in month 4 on day of week 1 (Sunday) with date 1 to 7, the tick at 01:59:59 gives 03:00:00. With it disabled, the same tick gives 02:00:00.
- R9: With daylight saving enabled, in month 10 on day of week 1 with date 25 to 31, the first tick at 01:59:59 gives 01:00:00. The repeated 01:59:59 then advances normally to 02:00:00.
- R10: While freeze is high, write-ready is high, ticks change no field and raise no strobe. A transfer loads the field chosen by the select code (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year), and code 7 changes nothing.
- R11: While freeze is low, write-ready is low and a held write-valid changes no field.
- R12: The update strobe is high for the one cycle that follows each advancing edge, which is the cycle in which the new values first appear, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| set_hold | input | 1 | Freeze: discards ticks and opens the write channel |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| dst_en | input | 1 | Enables daylight-saving hour shifts |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write channel can accept a transfer |
| wr_sel | input | 3 | Field select code for the write |
| wr_data | input | 8 | Field value in the current format |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (PM flag in bit 7 in 12-hour mode) |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | Date of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within the century |
| upd_done | output | 1 | High for one cycle after each advance |

## Verification
The hardest case to reach is the second pass through 01:59:59 on the October change date. The block must fall back once, then let the same hour pass normally. A host write clears the record of the fall-back, so the stimulus cannot load the repeated time directly. The bench loads 01:59:59 once, applies the fall-back tick, then holds the tick high for 3599 back-to-back cycles to reach the repeated 01:59:59 before the final tick. Year, month and leap boundaries are reached the same way: the bench loads the last second before the boundary and then applies a single tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW   = 8;
  localparam int NF   = 7;
  localparam int SELW = 3;

  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_DOW  = 3;
  localparam int I_DATE = 4;
  localparam int I_MON  = 5;
  localparam int I_YEAR = 6;

  typedef logic [FW-1:0]         fld_t;
  typedef logic [NF-1:0][FW-1:0] cal_arr_t;

  // reset calendar: 00:00:00, weekday 1, first of month 1, year 0
  localparam cal_arr_t CAL_RESET = {8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  function automatic fld_t bcd_to_bin(input fld_t v);
    fld_t t;
    t = {4'd0, v[7:4]};
    return (t << 3) + (t << 1) + {4'd0, v[3:0]};
  endfunction

  function automatic fld_t bin_to_bcd(input fld_t v);
    logic [3:0] tens;
    logic [3:0] units;
    tens  = 4'(v / 8'd10);
    units = 4'(v % 8'd10);
    return {tens, units};
  endfunction

  function automatic fld_t days_in_month(input fld_t mo, input fld_t yr);
    fld_t d;
    case (mo)
      8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
      8'd2:                    d = ((yr % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
      default:                 d = 8'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/cal_wr_decode.sv
module cal_wr_decode
  import cal_pkg::*;
(
  input  logic [FW-1:0] data_i,
  input  logic          is_hour,
  input  logic          bin_mode,
  input  logic          h24_mode,
  output logic [FW-1:0] val_o
);
  logic          twelve;
  logic [FW-1:0] raw_lo;
  logic [FW-1:0] conv;

  assign twelve = is_hour && !h24_mode;

  always_comb begin
    raw_lo = twelve ? {1'b0, data_i[FW-2:0]} : data_i;
    conv   = bin_mode ? raw_lo : bcd_to_bin(raw_lo);
    if (twelve) begin
      if (conv == 8'd12) val_o = data_i[FW-1] ? 8'd12 : 8'd0;
      else               val_o = data_i[FW-1] ? conv + 8'd12 : conv;
    end else begin
      val_o = conv;
    end
  end
endmodule

// File: rtl/cal_step.sv
module cal_step
  import cal_pkg::*;
(
  input  logic [NF-1:0][FW-1:0] cur_i,
  input  logic                  dst_en,
  input  logic                  fall_done,
  output logic [NF-1:0][FW-1:0] nxt_o,
  output logic                  fall_hit,
  output logic                  day_carry
);
  fld_t s, m, h, dw, dt, mo, y, dim;
  logic c_min, c_hr, c_day, c_mon, c_yr, at_0159, spring;

  always_comb begin
    s  = cur_i[I_SEC];
    m  = cur_i[I_MIN];
    h  = cur_i[I_HOUR];
    dw = cur_i[I_DOW];
    dt = cur_i[I_DATE];
    mo = cur_i[I_MON];
    y  = cur_i[I_YEAR];
    dim = days_in_month(mo, y);

    c_min = s >= 8'd59;
    c_hr  = c_min && (m >= 8'd59);
    c_day = c_hr && (h >= 8'd23);
    c_mon = c_day && (dt >= dim);
    c_yr  = c_mon && (mo >= 8'd12);

    nxt_o[I_SEC]  = c_min ? 8'd0 : s + 8'd1;
    nxt_o[I_MIN]  = c_hr ? 8'd0 : (c_min ? m + 8'd1 : m);
    nxt_o[I_HOUR] = c_day ? 8'd0 : (c_hr ? h + 8'd1 : h);
    nxt_o[I_DATE] = c_mon ? 8'd1 : (c_day ? dt + 8'd1 : dt);
    nxt_o[I_DOW]  = c_day ? ((dw >= 8'd7) ? 8'd1 : dw + 8'd1) : dw;
    nxt_o[I_MON]  = c_yr ? 8'd1 : (c_mon ? mo + 8'd1 : mo);
    nxt_o[I_YEAR] = c_yr ? ((y >= 8'd99) ? 8'd0 : y + 8'd1) : y;

    at_0159  = (h == 8'd1) && (m == 8'd59) && (s == 8'd59);
    spring   = dst_en && (mo == 8'd4) && (dw == 8'd1) && (dt <= 8'd7) && at_0159;
    fall_hit = dst_en && (mo == 8'd10) && (dw == 8'd1) && (dt >= 8'd25) && at_0159 && !fall_done;
    if (spring)   nxt_o[I_HOUR] = 8'd3;
    if (fall_hit) nxt_o[I_HOUR] = 8'd1;
    day_carry = c_day;
  end
endmodule

// File: rtl/cal_encode.sv
module cal_encode
  import cal_pkg::*;
(
  input  logic [NF-1:0][FW-1:0] cur_i,
  input  logic                  bin_mode,
  input  logic                  h24_mode,
  output logic [NF-1:0][FW-1:0] raw_o
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    if (i == I_HOUR) begin : g_hour
      fld_t h, h12, enc12;
      logic pm;
      always_comb begin
        h   = cur_i[i];
        pm  = h >= 8'd12;
        h12 = pm ? h - 8'd12 : h;
        if (h12 == 8'd0) h12 = 8'd12;
        enc12 = bin_mode ? h12 : bin_to_bcd(h12);
        if (h24_mode) raw_o[i] = bin_mode ? h : bin_to_bcd(h);
        else          raw_o[i] = {pm, enc12[FW-2:0]};
      end
    end else begin : g_plain
      assign raw_o[i] = bin_mode ? cur_i[i] : bin_to_bcd(cur_i[i]);
    end
  end
endmodule

// File: rtl/calendar_counter.sv
module calendar_counter
  import cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_1hz,
  input  logic            set_hold,
  input  logic            bin_mode,
  input  logic            h24_mode,
  input  logic            dst_en,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [SELW-1:0] wr_sel,
  input  logic [FW-1:0]   wr_data,
  output logic [FW-1:0]   sec_o,
  output logic [FW-1:0]   min_o,
  output logic [FW-1:0]   hour_o,
  output logic [FW-1:0]   dow_o,
  output logic [FW-1:0]   date_o,
  output logic [FW-1:0]   month_o,
  output logic [FW-1:0]   year_o,
  output logic            upd_done
);
  cal_arr_t cal_q, cal_n, cal_raw;
  fld_t     wr_val;
  logic     fall_q, fall_hit, day_carry, upd_q;
  logic     wr_fire, adv;

  assign wr_ready = set_hold;
  assign wr_fire  = wr_valid && set_hold;
  assign adv      = tick_1hz && !set_hold;

  cal_wr_decode u_dec (
    .data_i   (wr_data),
    .is_hour  (wr_sel == SELW'(I_HOUR)),
    .bin_mode (bin_mode),
    .h24_mode (h24_mode),
    .val_o    (wr_val)
  );

  cal_step u_step (
    .cur_i     (cal_q),
    .dst_en    (dst_en),
    .fall_done (fall_q),
    .nxt_o     (cal_n),
    .fall_hit  (fall_hit),
    .day_carry (day_carry)
  );

  cal_encode u_enc (
    .cur_i    (cal_q),
    .bin_mode (bin_mode),
    .h24_mode (h24_mode),
    .raw_o    (cal_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= CAL_RESET;
      fall_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= adv;
      if (wr_fire) begin
        for (int i = 0; i < NF; i++)
          if (wr_sel == SELW'(i)) cal_q[i] <= wr_val;
        fall_q <= 1'b0;
      end else if (adv) begin
        cal_q  <= cal_n;
        fall_q <= (fall_q || fall_hit) && !day_carry;
      end
    end
  end

  assign sec_o    = cal_raw[I_SEC];
  assign min_o    = cal_raw[I_MIN];
  assign hour_o   = cal_raw[I_HOUR];
  assign dow_o    = cal_raw[I_DOW];
  assign date_o   = cal_raw[I_DATE];
  assign month_o  = cal_raw[I_MON];
  assign year_o   = cal_raw[I_YEAR];
  assign upd_done = upd_q;
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       set_hold,
  input logic       bin_mode,
  input logic       h24_mode,
  input logic       wr_valid,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       upd_done
);
  a_r12_strobe_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !set_hold) |=> upd_done);

  a_r12_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> ($past(tick_1hz) && !$past(set_hold)));

  a_r10_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hold && !wr_valid) ##1 ($stable(bin_mode) && $stable(h24_mode)) |->
      ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(dow_o) &&
       $stable(date_o) && $stable(month_o) && $stable(year_o)));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !set_hold) ##1 ($stable(bin_mode) && $stable(h24_mode)) |->
      ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(dow_o) &&
       $stable(date_o) && $stable(month_o) && $stable(year_o)));

  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !set_hold && bin_mode && (sec_o < 8'd59)) ##1 $stable(bin_mode) |->
      (sec_o == $past(sec_o) + 8'd1));

  a_r3_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !set_hold) |=> ((dow_o >= 8'd1) && (dow_o <= 8'd7)));

  a_r7_hour_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !h24_mode |-> (hour_o[6:0] != 7'd0));
endmodule

bind calendar_counter cal_checker u_chk (.*);

// File: tb/sim_calendar_counter.sv
module sim_calendar_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, set_hold = 1'b0;
  logic bin_mode = 1'b0, h24_mode = 1'b1, dst_en = 1'b0, wr_valid = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, upd_done;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int m_t[7];
  bit m_fall, m_upd;

  always #(CLK_PERIOD/2) clk = ~clk;

  calendar_counter u0 (.*);

  function automatic int enc(int v);
    return bin_mode ? v : ((v / 10) * 16 + v % 10);
  endfunction
  function automatic int enc_hour(int h);
    int h12;
    if (h24_mode) return enc(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return ((h >= 12) ? 128 : 0) + enc(h12);
  endfunction
  function automatic int dec(int r);
    return bin_mode ? r : ((r / 16) * 10 + r % 16);
  endfunction
  function automatic int dec_hour(int r);
    int v;
    if (h24_mode) return dec(r);
    v = dec(r % 128);
    if (v == 12) return (r >= 128) ? 12 : 0;
    return (r >= 128) ? v + 12 : v;
  endfunction
  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic int port_val(int i);
    case (i)
      0: return int'(sec_o);
      1: return int'(min_o);
      2: return int'(hour_o);
      3: return int'(dow_o);
      4: return int'(date_o);
      5: return int'(month_o);
      default: return int'(year_o);
    endcase
  endfunction

  task automatic model_adv();
    bit sp, fa;
    sp = dst_en && m_t[5] == 4 && m_t[3] == 1 && m_t[4] <= 7 &&
         m_t[2] == 1 && m_t[1] == 59 && m_t[0] == 59;
    fa = dst_en && m_t[5] == 10 && m_t[3] == 1 && m_t[4] >= 25 &&
         m_t[2] == 1 && m_t[1] == 59 && m_t[0] == 59 && !m_fall;
    m_t[0]++;
    if (m_t[0] >= 60) begin
      m_t[0] = 0; m_t[1]++;
      if (m_t[1] >= 60) begin
        m_t[1] = 0; m_t[2]++;
        if (m_t[2] >= 24) begin
          m_t[2] = 0; m_t[3] = m_t[3] % 7 + 1; m_fall = 0; m_t[4]++;
          if (m_t[4] > mdays(m_t[5], m_t[6])) begin
            m_t[4] = 1; m_t[5]++;
            if (m_t[5] > 12) begin m_t[5] = 1; m_t[6] = (m_t[6] + 1) % 100; end
          end
        end
      end
    end
    if (sp) m_t[2] = 3;
    if (fa) begin m_t[2] = 1; m_fall = 1; end
  endtask

  // behavioural reference, stepped on the same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = '{0, 0, 0, 1, 1, 1, 0};
      m_fall = 0; m_upd = 0;
    end else begin
      m_upd = tick_1hz && !set_hold;
      if (set_hold && wr_valid) begin
        if (wr_sel < 7) m_t[wr_sel] = (wr_sel == 2) ? dec_hour(int'(wr_data)) : dec(int'(wr_data));
        m_fall = 0;
      end else if (tick_1hz && !set_hold) model_adv();
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      for (int i = 0; i < 7; i++) begin
        int e;
        e = (i == 2) ? enc_hour(m_t[i]) : enc(m_t[i]);
        if (port_val(i) != e)
          chk((i <= 2) ? "R2" : ((i == 3) ? "R3" : "R4"), "model field", port_val(i), e);
      end
      n_chk++;
      if (upd_done != m_upd) chk("R12", "model strobe", int'(upd_done), int'(m_upd));
      if (wr_ready != set_hold) chk("R10", "model ready", int'(wr_ready), int'(set_hold));
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk); wr_sel = 3'(sel); wr_data = 8'(data); wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
  endtask
  task automatic load(int s, int mi, int h, int dw, int dt, int mo, int y);
    @(negedge clk); set_hold = 1'b1;
    wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
    set_hold = 1'b0;
  endtask
  task automatic tick1();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask
  task automatic tickn(int n);
    @(negedge clk); tick_1hz = 1'b1;
    repeat (n) @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "sec", sec_o, 0);   chk("R1", "hour", hour_o, 0);
    chk("R1", "dow", dow_o, 1);   chk("R1", "date", date_o, 1);
    chk("R1", "month", month_o, 1); chk("R1", "year", year_o, 0);
    chk("R1", "strobe", upd_done, 0);

    // R2 / R3 / R4: carry through every field into the century wrap (BCD)
    load('h58, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99);
    tick1(); chk("R2", "sec step", sec_o, 'h59);
    chk("R12", "strobe after advance", upd_done, 1);
    @(negedge clk); chk("R12", "strobe one cycle", upd_done, 0);
    tick1();
    chk("R2", "hour wrap", hour_o, 'h00); chk("R3", "dow wrap", dow_o, 'h01);
    chk("R4", "date wrap", date_o, 'h01); chk("R4", "month wrap", month_o, 'h01);
    chk("R4", "year wrap", year_o, 'h00);

    // R5: leap and non-leap February
    load('h59, 'h59, 'h23, 'h03, 'h28, 'h02, 'h24);
    tick1(); chk("R5", "leap feb 29", date_o, 'h29);
    load('h59, 'h59, 'h23, 'h03, 'h29, 'h02, 'h24);
    tick1(); chk("R5", "leap to march", month_o, 'h03);
    load('h59, 'h59, 'h23, 'h03, 'h28, 'h02, 'h23);
    tick1(); chk("R5", "plain feb end", date_o, 'h01);
    load('h59, 'h59, 'h23, 'h03, 'h28, 'h02, 'h00);
    tick1(); chk("R5", "year 0 leap", date_o, 'h29);

    // R4: 30-day month
    load('h59, 'h59, 'h23, 'h05, 'h30, 'h04, 'h31);
    tick1(); chk("R4", "april end", month_o, 'h05);

    // R6: binary format and presentation switch
    bin_mode = 1'b1;
    load(58, 59, 23, 2, 14, 7, 45);
    chk("R6", "binary hour", hour_o, 23);
    tick1(); chk("R6", "binary sec", sec_o, 59);
    tick1(); chk("R6", "binary carry", date_o, 15);
    @(negedge clk); bin_mode = 1'b0;
    @(negedge clk); chk("R6", "same year as BCD", year_o, 'h45);

    // R7: 12-hour form
    h24_mode = 1'b0;
    load('h59, 'h59, 'h11, 'h02, 'h15, 'h06, 'h24);
    tick1(); chk("R7", "noon", hour_o, 'h92);
    load('h59, 'h59, 'h91, 'h02, 'h15, 'h06, 'h24);
    tick1(); chk("R7", "midnight", hour_o, 'h12); chk("R7", "day carry", date_o, 'h16);
    h24_mode = 1'b1;

    // R8: spring forward, then disabled
    dst_en = 1'b1;
    load('h59, 'h59, 'h01, 'h01, 'h05, 'h04, 'h24);
    tick1(); chk("R8", "spring hour", hour_o, 'h03); chk("R8", "spring min", min_o, 'h00);
    dst_en = 1'b0;
    load('h59, 'h59, 'h01, 'h01, 'h05, 'h04, 'h24);
    tick1(); chk("R8", "disabled", hour_o, 'h02);

    // R9: fall back once, repeated hour runs through
    dst_en = 1'b1;
    load('h59, 'h59, 'h01, 'h01, 'h27, 'h10, 'h24);
    tick1(); chk("R9", "fall back", hour_o, 'h01);
    tickn(3599);
    chk("R9", "repeat 01:59:59", sec_o, 'h59); chk("R9", "repeat hour", hour_o, 'h01);
    tick1(); chk("R9", "no second fall", hour_o, 'h02);
    dst_en = 1'b0;

    // R10: freeze ignores ticks, code 7 ignored, direct load
    @(negedge clk); set_hold = 1'b1;
    tick1(); chk("R10", "frozen sec", sec_o, 'h00); chk("R10", "no strobe", upd_done, 0);
    chk("R10", "ready", wr_ready, 1);
    wr(7, 'h33); chk("R10", "code 7 sec", sec_o, 'h00); chk("R10", "code 7 year", year_o, 'h24);
    wr(0, 'h42); chk("R10", "load sec", sec_o, 'h42);
    @(negedge clk); set_hold = 1'b0;

    // R11: write without freeze ignored
    @(negedge clk); chk("R11", "not ready", wr_ready, 0);
    wr(0, 'h11); chk("R11", "sec kept", sec_o, 'h42);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule